// File: doc/BRIEF.md
# Table Pointer Access Controller

This block moves single bytes between an 8-bit holding latch and a byte-addressed program memory. A 21-bit pointer selects the memory byte. A transfer starts when the block is idle and the command word on its input is one of the eight table-transfer codes. Bit 2 of the word picks the direction. The two low bits pick how the pointer moves around the access: it can stay put, advance after the access, step back after the access, or advance before the access.

Every transfer takes two cycles. In the first cycle the block drives the address together with a one-cycle read or write strobe to a synchronous memory. In the second cycle it takes in the returned byte on a read, and it applies any post-access change to the pointer. While it is idle, software-side logic can load the pointer and the latch directly through load ports.

Top module: `tbl_xfer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pointer, latch, busy, done, mem_rd and mem_wr are all zero.
- R2: A command is accepted only when the block is idle, cmd_valid is high and cmd_word is in the range 0x0008 to 0x000F (bits 15:3 equal 0x0001). Any other word leaves every output unchanged and raises no strobe.
- R3: A read (cmd_word bit 2 = 0) raises mem_rd for exactly the cycle after acceptance. The byte that the memory returns on the following clock edge is in the latch when done is high.
- R4: A write (cmd_word bit 2 = 1) raises mem_wr for exactly the cycle after acceptance, with mem_wdata equal to the latch. The latch is unchanged by the write.
- R5: Mode 00 (cmd_word bits 1:0) addresses the pointer and leaves it unchanged.
- R6: Mode 01 addresses the old pointer, and the pointer is old+1 from the done cycle onward.
- R7: Mode 10 addresses the old pointer, and the pointer is old-1 from the done cycle onward.
- R8: Mode 11 sets the pointer to old+1 in the strobe cycle and addresses that new value. During any strobe, mem_addr equals the pointer.
- R9: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF+1 gives 0 and 0-1 gives 0x1FFFFF.
- R10: busy is high for the two cycles after acceptance. done is a one-cycle pulse in the cycle right after those two, with busy low. Commands presented while busy are ignored.
- R11: ptr_ld / lat_ld load the pointer / latch on the next edge only when idle and no command is accepted in the same cycle. Loads while busy or alongside an accepted command are ignored. The pointer holds still between the strobe cycle and done.
- R12: mem_rd and mem_wr are never high together, and each is high only while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 16 | Instruction word |
| ptr_ld | input | 1 | Load pointer when idle |
| ptr_ld_val | input | 21 | Value for pointer load |
| lat_ld | input | 1 | Load latch when idle |
| lat_ld_val | input | 8 | Value for latch load |
| mem_rdata | input | 8 | Byte returned by memory one edge after mem_rd |
| mem_addr | output | 21 | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| ptr | output | 21 | Current pointer |
| latch | output | 8 | Current latch |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete pulse |

## Verification
If the stored mode is corrupted, the pointer shows the wrong value either in the strobe cycle (for a wrong pre-increment) or two cycles later at done (for a wrong post-step). A pre-increment applied at the wrong time also shows up immediately as a mismatch between mem_addr and the expected address. A phase register that skips or repeats a state shows up within one cycle: a strobe appears with nothing expected, busy has the wrong length, or done arrives late. A latch captured from the wrong edge shows up as a wrong byte at the done pulse.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
    localparam int PTR_W  = 21;
    localparam int DATA_W = 8;
    localparam int WORD_W = 16;
    localparam int MODE_W = 2;
    // upper code of table-transfer words: bits above bit 2 must read 1
    localparam logic [WORD_W-4:0] XFER_CODE = 13'h0001;

    typedef enum logic [MODE_W-1:0] {
        MODE_KEEP     = 2'b00,
        MODE_POST_INC = 2'b01,
        MODE_POST_DEC = 2'b10,
        MODE_PRE_INC  = 2'b11
    } step_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_FINISH = 2'd2
    } phase_e;

    typedef enum logic {
        STAGE_PRE  = 1'b0,
        STAGE_POST = 1'b1
    } stage_e;

    typedef struct packed {
        phase_e              phase;
        step_mode_e          mode;
        logic                is_wr;
        logic [PTR_W-1:0]    ptr;
        logic [DATA_W-1:0]   lat;
        logic [PTR_W-1:0]    addr;
        logic [DATA_W-1:0]   wdata;
        logic                rd;
        logic                wr;
        logic                done;
    } ctrl_state_t;
endpackage

// File: rtl/tblx_decode.sv
module tblx_decode
    import tblx_pkg::*;
#(
    parameter int WORD_BITS = WORD_W
) (
    input  logic [WORD_BITS-1:0] word,
    output logic                 hit,
    output logic                 is_wr,
    output step_mode_e           mode
);
    localparam int CODE_LSB = 3;

    always_comb begin
        hit   = (word[WORD_BITS-1:CODE_LSB] == XFER_CODE);
        is_wr = word[2];
        mode  = step_mode_e'(word[MODE_W-1:0]);
    end
endmodule

// File: rtl/tblx_ptr_step.sv
module tblx_ptr_step
    import tblx_pkg::*;
#(
    parameter int     AW    = PTR_W,
    parameter stage_e STAGE = STAGE_PRE
) (
    input  logic [AW-1:0] cur,
    input  step_mode_e    mode,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] plus_one;
    logic [AW-1:0] minus_one;

    always_comb begin
        plus_one  = cur + ONE;
        minus_one = cur - ONE;
    end

    generate
        if (STAGE == STAGE_PRE) begin : g_pre
            always_comb begin
                nxt = (mode == MODE_PRE_INC) ? plus_one : cur;
            end
        end else begin : g_post
            always_comb begin
                unique case (mode)
                    MODE_POST_INC: nxt = plus_one;
                    MODE_POST_DEC: nxt = minus_one;
                    default:       nxt = cur;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/tbl_xfer_ctrl.sv
module tbl_xfer_ctrl
    import tblx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_ld_val,
    input  logic              lat_ld,
    input  logic [DATA_W-1:0] lat_ld_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] latch,
    output logic              busy,
    output logic              done
);
    ctrl_state_t st_q, st_d;

    logic       dec_hit;
    logic       dec_wr;
    step_mode_e dec_mode;
    logic [PTR_W-1:0] pre_ptr;
    logic [PTR_W-1:0] post_ptr;
    logic       take_cmd;

    tblx_decode #(.WORD_BITS(WORD_W)) u_dec (
        .word  (cmd_word),
        .hit   (dec_hit),
        .is_wr (dec_wr),
        .mode  (dec_mode)
    );

    tblx_ptr_step #(.AW(PTR_W), .STAGE(STAGE_PRE)) u_pre (
        .cur  (st_q.ptr),
        .mode (dec_mode),
        .nxt  (pre_ptr)
    );

    tblx_ptr_step #(.AW(PTR_W), .STAGE(STAGE_POST)) u_post (
        .cur  (st_q.ptr),
        .mode (st_q.mode),
        .nxt  (post_ptr)
    );

    always_comb begin
        take_cmd = (st_q.phase == PH_IDLE) && cmd_valid && dec_hit;
        st_d      = st_q;
        st_d.rd   = 1'b0;
        st_d.wr   = 1'b0;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (take_cmd) begin
                    st_d.phase = PH_ACCESS;
                    st_d.mode  = dec_mode;
                    st_d.is_wr = dec_wr;
                    st_d.ptr   = pre_ptr;
                    st_d.addr  = pre_ptr;
                    st_d.wdata = st_q.lat;
                    st_d.rd    = ~dec_wr;
                    st_d.wr    = dec_wr;
                end else begin
                    if (ptr_ld) st_d.ptr = ptr_ld_val;
                    if (lat_ld) st_d.lat = lat_ld_val;
                end
            end
            PH_ACCESS: begin
                st_d.phase = PH_FINISH;
            end
            PH_FINISH: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.ptr   = post_ptr;
                if (!st_q.is_wr) st_d.lat = mem_rdata;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, mode: MODE_KEEP, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_addr  = st_q.addr;
        mem_rd    = st_q.rd;
        mem_wr    = st_q.wr;
        mem_wdata = st_q.wdata;
        ptr       = st_q.ptr;
        latch     = st_q.lat;
        busy      = (st_q.phase != PH_IDLE);
        done      = st_q.done;
    end
endmodule

// File: rtl/tbl_xfer_ctrl_chk.sv
module tbl_xfer_ctrl_chk
    import tblx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PTR_W-1:0]  mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [PTR_W-1:0]  ptr,
    input logic [DATA_W-1:0] latch,
    input logic              busy,
    input logic              done
);
    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_strobe_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    assert_addr_is_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr == ptr));

    assert_wdata_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == latch));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> (busy && !mem_rd && !mem_wr));

    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> $stable(ptr));
endmodule

bind tbl_xfer_ctrl tbl_xfer_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .latch     (latch),
    .busy      (busy),
    .done      (done)
);

// File: tb/tbl_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module tbl_xfer_ctrl_tb;
    localparam int PW = 21;
    localparam int DW = 8;
    localparam logic [PW-1:0] PMAX = 21'h1FFFFF;

    typedef struct {
        logic [PW-1:0] addr;
        logic          is_wr;
        logic [DW-1:0] wdata;
        logic [PW-1:0] ptr_after;
        logic [DW-1:0] lat_after;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic ptr_ld = 1'b0;
    logic [PW-1:0] ptr_ld_val = '0;
    logic lat_ld = 1'b0;
    logic [DW-1:0] lat_ld_val = '0;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] mem_addr;
    logic mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [PW-1:0] ptr;
    logic [DW-1:0] latch;
    logic busy, done;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb[$];
    logic [DW-1:0] mem [256];
    logic [DW-1:0] ref_mem [256];
    logic [PW-1:0] m_ptr = '0;
    logic [DW-1:0] m_lat = '0;

    always #2.5 clk = ~clk;

    tbl_xfer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val), .lat_ld(lat_ld),
        .lat_ld_val(lat_ld_val), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .ptr(ptr),
        .latch(latch), .busy(busy), .done(done)
    );

    // synchronous byte memory
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares strobes and completions with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd || mem_wr) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2/R10 unexpected strobe", {11'd0, mem_addr}, 32'd0);
                end else begin
                    chk(mem_addr == sb[0].addr, "R5-R8 address", mem_addr, sb[0].addr);
                    chk(mem_wr == sb[0].is_wr, "R3/R4 direction", mem_wr, sb[0].is_wr);
                    chk(!(mem_rd && mem_wr), "R12 exclusive strobes", {mem_rd, mem_wr}, 0);
                    if (sb[0].is_wr)
                        chk(mem_wdata == sb[0].wdata, "R4 write data", mem_wdata, sb[0].wdata);
                end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    chk(ptr == sb[0].ptr_after, "R5-R7/R9 pointer at done", ptr, sb[0].ptr_after);
                    chk(latch == sb[0].lat_after, "R3/R4 latch at done", latch, sb[0].lat_after);
                    chk(!busy, "R10 busy low at done", busy, 0);
                    void'(sb.pop_front());
                end
            end
        end
    end

    task automatic set_ptr(input logic [PW-1:0] v);
        @(negedge clk); ptr_ld = 1'b1; ptr_ld_val = v;
        @(negedge clk); ptr_ld = 1'b0;
        m_ptr = v;
        chk(ptr == v, "R11 pointer load", ptr, v);
    endtask

    task automatic set_lat(input logic [DW-1:0] v);
        @(negedge clk); lat_ld = 1'b1; lat_ld_val = v;
        @(negedge clk); lat_ld = 1'b0;
        m_lat = v;
        chk(latch == v, "R11 latch load", latch, v);
    endtask

    // noise: 0 none, 1 junk during busy, 2 load beside accepted command
    task automatic issue(input logic [15:0] w, input int noise);
        exp_t e;
        logic [PW-1:0] old;
        logic [1:0] md;
        old = m_ptr;
        md = w[1:0];
        e.is_wr = w[2];
        e.addr = (md == 2'b11) ? old + 1'b1 : old;
        case (md)
            2'b01: e.ptr_after = old + 1'b1;
            2'b10: e.ptr_after = old - 1'b1;
            2'b11: e.ptr_after = old + 1'b1;
            default: e.ptr_after = old;
        endcase
        e.wdata = m_lat;
        if (e.is_wr) begin
            ref_mem[e.addr[7:0]] = m_lat;
            e.lat_after = m_lat;
        end else begin
            e.lat_after = ref_mem[e.addr[7:0]];
        end
        sb.push_back(e);
        m_ptr = e.ptr_after;
        m_lat = e.lat_after;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = w;
        if (noise == 2) begin
            ptr_ld = 1'b1; ptr_ld_val = 21'h0ABCDE;
            lat_ld = 1'b1; lat_ld_val = ~m_lat;
        end
        @(negedge clk);
        cmd_valid = 1'b0; ptr_ld = 1'b0; lat_ld = 1'b0;
        chk(busy, "R10 busy first cycle", busy, 1);
        chk(ptr == e.addr, "R8 pointer in strobe cycle", ptr, e.addr);
        if (noise == 1) begin
            cmd_valid = 1'b1; cmd_word = 16'h000B;
            ptr_ld = 1'b1; ptr_ld_val = 21'h155555;
            lat_ld = 1'b1; lat_ld_val = 8'h3C;
        end
        @(negedge clk);
        chk(busy && !mem_rd && !mem_wr, "R10 busy second cycle", {busy, mem_rd, mem_wr}, 3'b100);
        @(negedge clk);
        cmd_valid = 1'b0; ptr_ld = 1'b0; lat_ld = 1'b0;
        chk(done, "R10 done pulse", done, 1);
        @(negedge clk);
        chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);
        chk(ptr == m_ptr && latch == m_lat, "R10/R11 state after busy inputs",
            {ptr, latch}, {m_ptr, m_lat});
    endtask

    task automatic ignore(input logic [15:0] w);
        @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (3) begin
            chk(!busy && !mem_rd && !mem_wr && !done, "R2 ignored word idle",
                {busy, mem_rd, mem_wr, done}, 0);
            @(negedge clk);
        end
        chk(ptr == m_ptr && latch == m_lat, "R2 ignored word state", {ptr, latch}, {m_ptr, m_lat});
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + 11);
            ref_mem[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ptr == 0 && latch == 0, "R1 reset pointer/latch", {ptr, latch}, 0);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1 reset controls",
            {busy, done, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        set_ptr(21'h000010);
        set_lat(8'hA5);
        issue(16'h0008, 0); // R3 R5 read keep
        issue(16'h0009, 0); // R6 read post-inc
        issue(16'h000A, 0); // R7 read post-dec
        issue(16'h000B, 0); // R8 read pre-inc
        set_lat(8'h5A);
        issue(16'h000C, 0); // R4 write keep
        issue(16'h0008, 0); // read back written byte
        set_lat(8'hC3);
        issue(16'h000D, 0);
        issue(16'h000E, 0);
        issue(16'h000F, 0);
        issue(16'h000A, 0);
        issue(16'h0009, 0);

        // R9 wrap
        set_ptr(PMAX);
        issue(16'h0009, 0);
        chk(ptr == 0, "R9 wrap up", ptr, 0);
        issue(16'h000A, 0);
        chk(ptr == PMAX, "R9 wrap down", ptr, PMAX);
        issue(16'h000F, 0);
        chk(ptr == 0, "R9 pre-inc wrap", ptr, 0);
        issue(16'h000E, 0);

        // R2 non-table words
        ignore(16'h0007);
        ignore(16'h0010);
        ignore(16'h0108);
        ignore(16'h8008);
        ignore(16'hF00C);

        // R10 R11 inputs while busy, and loads beside accepted command
        set_ptr(21'h000040);
        issue(16'h0009, 1);
        issue(16'h000D, 1);
        issue(16'h0008, 2);
        issue(16'h000F, 2);

        for (int i = 0; i < 24; i++) begin
            if (i % 5 == 0) set_lat(8'(i * 29 + 7));
            issue(16'h0008 | 16'(i % 8), 0);
        end

        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R10 all transfers completed", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule